// File: doc/BRIEF.md
# PHY Power-Down Request Arbiter

This block sits between a DRAM controller and its PHY and decides when the PHY may drop into a power-down state. It also decides which 4-bit wake-up latency code goes with that request. The code tells the PHY how deep it may sleep. A deeper level saves more power but needs longer to come back.

There are three sources of a power-down demand, checked in a fixed priority order:
- A Q-channel power-down sequence, which always uses a tie-off code.
- A direct software command, which carries its own code.
- The memory's current power-saving state, which uses a programmable code for each low-power state.

The idle-ready state never produces a demand, because it is the only state in which commands may be issued. Clock stop and maximum power-down can each be switched off for memories that lack them.

The request is a registered level. After it drops, the block waits until the PHY acknowledge is low before it raises a new request. If the selected source, state or code changes while a request is up, the block first drops the request and then raises it again with the new code.

Top module: `phy_pd_arbiter`

## Requirements
- R1: After a synchronous reset, `phy_pd_req`, `busy` and `phy_wake` are all 0.
- R2: With no software or Q-channel demand, `mem_state` values 0 (idle-ready), 6 and 7 never produce a request.
- R3: `mem_state` values 1 to 5 mean clock stop, active power-down, precharge power-down, self-refresh and maximum power-down. For each of these states, the request rises one cycle after the state is seen and the PHY acknowledge is low. The code sent is `state_wake[(s-1)*4 +: 4]`.
- R4: When `clkstop_en` is 0, state 1 is treated like idle-ready. When `maxpd_en` is 0, state 5 is treated like idle-ready.
- R5: While `sw_pd_req` is high and `qch_pd_req` is low, the code sent is `sw_wake`, whatever the memory state.
- R6: While `qch_pd_req` is high, the code sent is `qch_wake_tie`, whatever the software and state inputs.
- R7: `phy_wake` does not change while `phy_pd_req` stays high.
- R8: When every demand is gone, the request drops one cycle later. A new request rises only at an edge where `phy_ack` was low.
- R9: If the selected source, state or code changes while a request is high, the request goes low for at least one cycle. It then returns with the new code.
- R10: `busy` is high while a request is held and while the block waits for the acknowledge to clear; otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_state | input | 3 | Current memory power-saving state (0 idle-ready … 5 maximum power-down) |
| state_wake | input | 20 | Programmed wake codes, 4 bits per low-power state, state 1 in the low nibble |
| clkstop_en | input | 1 | Clock-stop state supported |
| maxpd_en | input | 1 | Maximum power-down state supported |
| sw_pd_req | input | 1 | Software power-down command active |
| sw_wake | input | 4 | Wake code carried by the software command |
| qch_pd_req | input | 1 | Q-channel sequence demands PHY power-down |
| qch_wake_tie | input | 4 | Tie-off wake code for Q-channel power-down |
| phy_ack | input | 1 | PHY acknowledge of the power-down request |
| phy_pd_req | output | 1 | Power-down request to the PHY |
| phy_wake | output | 4 | Wake-up code sent with the request |
| busy | output | 1 | Request held or acknowledge still pending |

## Verification
The assertions take all inputs as synchronous to `clk`. They also assume that `phy_ack` behaves like a PHY handshake that follows the request, although no property needs it to. The stimulus changes inputs only on the falling edge. It uses a modelled PHY whose acknowledge trails the request by two cycles. One extra control holds the acknowledge high, so that the wait-for-release path is exercised. Configuration codes change only in the phase that targets the drop-and-re-request behaviour.

// File: rtl/phy_pd_pkg.sv
package phy_pd_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_STATE = 2'd1,
    SRC_SW    = 2'd2,
    SRC_QCH   = 2'd3
  } pd_src_e;

  typedef enum logic [1:0] {
    FSM_IDLE  = 2'd0,
    FSM_REQ   = 2'd1,
    FSM_DRAIN = 2'd2
  } pd_fsm_e;

endpackage

// File: rtl/pd_state_decode.sv
module pd_state_decode #(
  parameter int WAKE_W  = 4,
  parameter int STATE_W = 3,
  parameter int NUM_LP  = 5
) (
  input  logic [STATE_W-1:0]       mem_state,
  input  logic [NUM_LP*WAKE_W-1:0] state_wake,
  input  logic                     clkstop_en,
  input  logic                     maxpd_en,
  output logic                     lp_valid,
  output logic [WAKE_W-1:0]        lp_code
);

  logic [NUM_LP-1:0] hit;

  // State k+1 maps to slot k; the shallowest and deepest slots are optional.
  for (genvar k = 0; k < NUM_LP; k++) begin : g_slot
    logic allowed;
    if (k == 0) begin : g_first
      assign allowed = clkstop_en;
    end else if (k == NUM_LP - 1) begin : g_last
      assign allowed = maxpd_en;
    end else begin : g_mid
      assign allowed = 1'b1;
    end
    assign hit[k] = allowed && (mem_state == STATE_W'(k + 1));
  end

  always_comb begin
    lp_code = '0;
    for (int k = 0; k < NUM_LP; k++) begin
      if (hit[k]) lp_code = state_wake[k*WAKE_W +: WAKE_W];
    end
  end

  assign lp_valid = |hit;

endmodule

// File: rtl/pd_source_select.sv
module pd_source_select
  import phy_pd_pkg::*;
#(
  parameter int WAKE_W  = 4,
  parameter int STATE_W = 3
) (
  input  logic               qch_pd_req,
  input  logic [WAKE_W-1:0]  qch_wake_tie,
  input  logic               sw_pd_req,
  input  logic [WAKE_W-1:0]  sw_wake,
  input  logic               lp_valid,
  input  logic [WAKE_W-1:0]  lp_code,
  input  logic [STATE_W-1:0] mem_state,
  output pd_src_e            sel_src,
  output logic [WAKE_W-1:0]  sel_code,
  output logic [STATE_W-1:0] sel_state
);

  always_comb begin
    sel_src   = SRC_NONE;
    sel_code  = '0;
    sel_state = '0;
    if (qch_pd_req) begin
      sel_src  = SRC_QCH;
      sel_code = qch_wake_tie;
    end else if (sw_pd_req) begin
      sel_src  = SRC_SW;
      sel_code = sw_wake;
    end else if (lp_valid) begin
      sel_src   = SRC_STATE;
      sel_code  = lp_code;
      sel_state = mem_state;
    end
  end

endmodule

// File: rtl/pd_req_fsm.sv
module pd_req_fsm
  import phy_pd_pkg::*;
#(
  parameter int WAKE_W  = 4,
  parameter int STATE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  pd_src_e            sel_src,
  input  logic [WAKE_W-1:0]  sel_code,
  input  logic [STATE_W-1:0] sel_state,
  input  logic               phy_ack,
  output logic               phy_pd_req,
  output logic [WAKE_W-1:0]  phy_wake,
  output logic               busy
);

  pd_fsm_e            fsm_q, fsm_d;
  pd_src_e            held_src_q;
  logic [STATE_W-1:0] held_state_q;
  logic [WAKE_W-1:0]  wake_q;
  logic               req_q, busy_q;
  logic               changed, load;

  assign changed = (sel_src != held_src_q) || (sel_code != wake_q) ||
                   (sel_state != held_state_q);

  always_comb begin
    fsm_d = fsm_q;
    load  = 1'b0;
    case (fsm_q)
      FSM_IDLE: begin
        if (sel_src != SRC_NONE && !phy_ack) begin
          fsm_d = FSM_REQ;
          load  = 1'b1;
        end
      end
      FSM_REQ: begin
        if (sel_src == SRC_NONE || changed) fsm_d = FSM_DRAIN;
      end
      FSM_DRAIN: begin
        if (!phy_ack) fsm_d = FSM_IDLE;
      end
      default: fsm_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q        <= FSM_IDLE;
      held_src_q   <= SRC_NONE;
      held_state_q <= '0;
      wake_q       <= '0;
      req_q        <= 1'b0;
      busy_q       <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      req_q  <= (fsm_d == FSM_REQ);
      busy_q <= (fsm_d != FSM_IDLE);
      if (load) begin
        held_src_q   <= sel_src;
        held_state_q <= sel_state;
        wake_q       <= sel_code;
      end
    end
  end

  assign phy_pd_req = req_q;
  assign phy_wake   = wake_q;
  assign busy       = busy_q;

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!phy_pd_req && !busy && phy_wake == '0));

  a_r2_req_needs_source: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_pd_req) |-> $past(sel_src != SRC_NONE));

  a_r3_code_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_pd_req) |-> phy_wake == $past(sel_code));

  a_r7_wake_stable: assert property (@(posedge clk) disable iff (rst)
    (phy_pd_req && $past(phy_pd_req)) |-> $stable(phy_wake));

  a_r8_rise_after_ack_low: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_pd_req) |-> !$past(phy_ack));

  a_r9_held_matches_sel: assert property (@(posedge clk) disable iff (rst)
    (phy_pd_req && $past(phy_pd_req)) |-> $past(sel_code) == phy_wake);

  a_r10_busy_covers_req: assert property (@(posedge clk) disable iff (rst)
    phy_pd_req |-> busy);

endmodule

// File: rtl/phy_pd_arbiter.sv
module phy_pd_arbiter
  import phy_pd_pkg::*;
#(
  parameter int WAKE_W  = 4,
  parameter int STATE_W = 3,
  parameter int NUM_LP  = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [STATE_W-1:0]       mem_state,
  input  logic [NUM_LP*WAKE_W-1:0] state_wake,
  input  logic                     clkstop_en,
  input  logic                     maxpd_en,
  input  logic                     sw_pd_req,
  input  logic [WAKE_W-1:0]        sw_wake,
  input  logic                     qch_pd_req,
  input  logic [WAKE_W-1:0]        qch_wake_tie,
  input  logic                     phy_ack,
  output logic                     phy_pd_req,
  output logic [WAKE_W-1:0]        phy_wake,
  output logic                     busy
);

  logic               lp_valid;
  logic [WAKE_W-1:0]  lp_code;
  pd_src_e            sel_src;
  logic [WAKE_W-1:0]  sel_code;
  logic [STATE_W-1:0] sel_state;

  pd_state_decode #(.WAKE_W(WAKE_W), .STATE_W(STATE_W), .NUM_LP(NUM_LP)) u_decode (
    .mem_state  (mem_state),
    .state_wake (state_wake),
    .clkstop_en (clkstop_en),
    .maxpd_en   (maxpd_en),
    .lp_valid   (lp_valid),
    .lp_code    (lp_code)
  );

  pd_source_select #(.WAKE_W(WAKE_W), .STATE_W(STATE_W)) u_select (
    .qch_pd_req   (qch_pd_req),
    .qch_wake_tie (qch_wake_tie),
    .sw_pd_req    (sw_pd_req),
    .sw_wake      (sw_wake),
    .lp_valid     (lp_valid),
    .lp_code      (lp_code),
    .mem_state    (mem_state),
    .sel_src      (sel_src),
    .sel_code     (sel_code),
    .sel_state    (sel_state)
  );

  pd_req_fsm #(.WAKE_W(WAKE_W), .STATE_W(STATE_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sel_src    (sel_src),
    .sel_code   (sel_code),
    .sel_state  (sel_state),
    .phy_ack    (phy_ack),
    .phy_pd_req (phy_pd_req),
    .phy_wake   (phy_wake),
    .busy       (busy)
  );

endmodule

// File: tb/phy_pd_arbiter_bench.sv
`timescale 1ns/1ps
module phy_pd_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mem_state = '0;
  logic [19:0] state_wake = '0;
  logic        clkstop_en = 1'b1;
  logic        maxpd_en = 1'b1;
  logic        sw_pd_req = 1'b0;
  logic [3:0]  sw_wake = '0;
  logic        qch_pd_req = 1'b0;
  logic [3:0]  qch_wake_tie = 4'hE;
  logic        ack_force = 1'b0;
  logic [1:0]  ack_pipe = '0;
  logic        phy_ack;
  logic        phy_pd_req, busy;
  logic [3:0]  phy_wake;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  assign phy_ack = ack_pipe[1] | ack_force;

  always @(posedge clk) begin
    if (rst) ack_pipe <= '0;
    else     ack_pipe <= {ack_pipe[0], phy_pd_req};
  end

  phy_pd_arbiter u_phy_pd_arbiter (
    .clk(clk), .rst(rst), .mem_state(mem_state), .state_wake(state_wake),
    .clkstop_en(clkstop_en), .maxpd_en(maxpd_en), .sw_pd_req(sw_pd_req),
    .sw_wake(sw_wake), .qch_pd_req(qch_pd_req), .qch_wake_tie(qch_wake_tie),
    .phy_ack(phy_ack), .phy_pd_req(phy_pd_req), .phy_wake(phy_wake), .busy(busy)
  );

  // Behavioural reference: 0 quiet, 1 requesting, 2 waiting for ack release
  int       m_mode = 0;
  int       m_src = 0;
  int       m_st = 0;
  bit [3:0] m_wake = '0;

  function automatic bit lp_ok(input int s);
    if (s < 1 || s > 5) return 0;
    if (s == 1 && !clkstop_en) return 0;
    if (s == 5 && !maxpd_en) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    int d_src, d_st;
    bit [3:0] d_code;
    if (rst) begin
      m_mode = 0; m_src = 0; m_st = 0; m_wake = '0;
    end else begin
      d_src = 0; d_st = 0; d_code = '0;
      if (qch_pd_req) begin d_src = 3; d_code = qch_wake_tie; end
      else if (sw_pd_req) begin d_src = 2; d_code = sw_wake; end
      else if (lp_ok(int'(mem_state))) begin
        d_src = 1; d_st = int'(mem_state);
        d_code = state_wake[(d_st-1)*4 +: 4];
      end
      if (m_mode == 0) begin
        if (d_src != 0 && !phy_ack) begin
          m_mode = 1; m_src = d_src; m_st = d_st; m_wake = d_code;
        end
      end else if (m_mode == 1) begin
        if (d_src == 0 || d_src != m_src || d_st != m_st || d_code != m_wake) m_mode = 2;
      end else begin
        if (!phy_ack) m_mode = 0;
      end
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, "phy_pd_req", int'(phy_pd_req), int'(m_mode == 1));
      check(tag, "busy", int'(busy), int'(m_mode != 0));
      check(tag, "phy_wake", int'(phy_wake), int'(m_wake));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    state_wake = {4'h5, 4'h4, 4'h3, 4'h2, 4'h1};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1"; step(1);
    check("R1", "reset phy_pd_req", int'(phy_pd_req), 0);
    check("R1", "reset phy_wake", int'(phy_wake), 0);

    tag = "R2";
    for (int s = 0; s < 8; s += 6) begin mem_state = 3'(s); step(4); end
    mem_state = 3'd7; step(4);
    check("R2", "idle no req", int'(phy_pd_req), 0);

    tag = "R3";
    for (int s = 1; s <= 5; s++) begin
      mem_state = 3'(s); step(8);
      check("R3", "state code", int'(phy_wake), s);
    end
    mem_state = 3'd0; step(6);

    tag = "R4";
    clkstop_en = 1'b0; mem_state = 3'd1; step(6);
    check("R4", "clkstop disabled", int'(phy_pd_req), 0);
    mem_state = 3'd0; maxpd_en = 1'b0; step(1);
    mem_state = 3'd5; step(6);
    check("R4", "maxpd disabled", int'(phy_pd_req), 0);
    clkstop_en = 1'b1; maxpd_en = 1'b1; mem_state = 3'd0; step(6);

    tag = "R5";
    sw_wake = 4'h9; sw_pd_req = 1'b1; step(6);
    check("R5", "sw code idle", int'(phy_wake), 9);
    mem_state = 3'd4; step(6);
    check("R5", "sw beats state", int'(phy_wake), 9);

    tag = "R6";
    qch_pd_req = 1'b1; step(8);
    check("R6", "qch tie code", int'(phy_wake), 14);
    sw_pd_req = 1'b0; step(6);
    qch_pd_req = 1'b0; step(8);
    check("R6", "back to state code", int'(phy_wake), 4);

    tag = "R9";
    state_wake[15:12] = 4'hB; step(8);
    check("R9", "new programmed code", int'(phy_wake), 11);
    mem_state = 3'd3; step(8);
    check("R9", "new state code", int'(phy_wake), 3);

    tag = "R8";
    ack_force = 1'b1; mem_state = 3'd0; step(3);
    mem_state = 3'd2; step(6);
    check("R8", "held ack blocks req", int'(phy_pd_req), 0);
    check("R10", "busy while waiting", int'(busy), 1);
    ack_force = 1'b0; step(6);
    check("R8", "req after release", int'(phy_pd_req), 1);

    tag = "R10";
    mem_state = 3'd0; step(6);
    check("R10", "busy clears", int'(busy), 0);

    tag = "R7";
    mem_state = 3'd5; step(3);
    sw_wake = 4'h1; step(2);
    check("R7", "wake held", int'(phy_wake), 5);
    mem_state = 3'd0; step(6);

    tag = "R1";
    rst = 1'b1; step(1); rst = 1'b0; step(1);
    check("R1", "re-reset wake", int'(phy_wake), 0);
    finish_run();
  end

endmodule